// File: doc/BRIEF.md
# Received Frame Length Log

This block keeps one status record for every bit-oriented synchronous frame that the receiver finishes, so several frames can land before software has to collect their lengths. It sits after the flag hunter and the CRC checker, and it sees only single-cycle pulses from them. These are a byte strobe for each received data byte, a flag pulse for each flag sequence that does not end a frame, and an end-of-frame pulse on the flag that closes a frame. The end-of-frame pulse comes with a five-bit status word.

A small controller with two named states tracks framing. `ST_HUNT` waits for the first opening flag and counts nothing. `ST_COUNT` counts bytes with a saturating counter. On a closing flag it packs the count and the status into an entry and pushes it into a ten-deep store, then clears the counter. The controller stays in `ST_COUNT` because a closing flag may also open the next frame. The transitions are:

- HUNT_TO_COUNT: an opening flag while enabled.
- COUNT_TO_HUNT: enable going low.
- COUNT_HOLD: every other cycle.

Software reads the oldest entry at the head of the store and pops it with a read strobe. The empty, full and level outputs show how far the store has filled. A sticky overflow bit records any frame that had no room.

Top module: `frmstat_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, level is 0, overflow is 0 and the controller is in ST_HUNT.
- R2: In ST_COUNT each byte strobe adds one to the byte count. The count stored for a frame equals the byte strobes since the last flag or end-of-frame pulse, including a byte strobe in the same cycle as the closing end-of-frame pulse.
- R3: In ST_HUNT, byte strobes are not counted and an end-of-frame pulse writes nothing. The first flag pulse moves the controller to ST_COUNT with the count at zero and writes nothing.
- R4: An end-of-frame pulse in ST_COUNT writes one entry: frame_status in bits [18:14] and the byte count in bits [13:0]. The count then restarts from zero and the controller stays in ST_COUNT.
- R5: A flag pulse in ST_COUNT without an end-of-frame pulse clears the count and writes nothing. When both pulses arrive in the same cycle, the end-of-frame pulse wins and one entry is written.
- R6: The store holds 10 entries and returns them oldest first on head_entry. Level gives the number held, full is 1 exactly at 10, and empty is 1 exactly at 0.
- R7: A read strobe removes the head entry. A read strobe on an empty store has no effect.
- R8: An end-of-frame write to a full store without a read in the same cycle is dropped and sets overflow, which stays set until reset. A write together with a read on a full store performs both, keeps level at 10 and does not set overflow.
- R9: While enable is 0 no entry is written and the controller returns to ST_HUNT. After enable returns, a new opening flag is needed before frames are logged. Reads still work while enable is 0.
- R10: The byte count saturates at 16383 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Logging enable |
| byte_stb | input | 1 | One pulse per received byte |
| flag_stb | input | 1 | Flag seen that does not close a frame |
| eof_stb | input | 1 | Closing flag of a frame |
| frame_status | input | 5 | Status word stored with the closing flag |
| rd_stb | input | 1 | Pop the head entry |
| head_entry | output | 19 | Oldest entry: status [18:14], byte count [13:0] |
| empty | output | 1 | Store holds no entry |
| full | output | 1 | Store holds 10 entries |
| level | output | 4 | Number of entries held |
| overflow | output | 1 | Sticky: a frame was dropped for lack of room |

## Verification
A frame write and a software pop can fall in the same clock edge. The case that matters is a full store, where the write is legal only because the pop frees a slot. The bench fills the store with ten frames and then issues an end-of-frame pulse and a read strobe in one cycle. It then checks three things: the popped entry matches the scoreboard's oldest item, level stays at 10, and overflow stays clear. A second write without a read must then set overflow, and draining the store must show the new frame behind the older ones.

// File: rtl/frmstat_pkg.sv
package frmstat_pkg;

    localparam int DEF_CNT_W  = 14;
    localparam int DEF_STAT_W = 5;
    localparam int DEF_DEPTH  = 10;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_COUNT = 1'b1
    } trk_state_t;

endpackage

// File: rtl/frmstat_track.sv
module frmstat_track
    import frmstat_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int STAT_W = DEF_STAT_W,
    localparam int ENT_W = CNT_W + STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_stb,
    input  logic              flag_stb,
    input  logic              eof_stb,
    input  logic [STAT_W-1:0] status_in,
    output logic              push,
    output logic [ENT_W-1:0]  push_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              in_hunt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    trk_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cnt_inc;

    // saturating increment, includes a byte arriving this cycle
    assign cnt_inc   = (byte_stb && (cnt != CNT_MAX)) ? cnt + 1'b1 : cnt;
    assign push_data = {status_in, cnt_inc};
    assign in_hunt   = (state == ST_HUNT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        push      = 1'b0;
        unique case (state)
            ST_HUNT: begin
                cnt_nxt = '0;
                if (enable && flag_stb) begin
                    state_nxt = ST_COUNT;      // HUNT_TO_COUNT
                end
            end
            ST_COUNT: begin
                if (!enable) begin
                    state_nxt = ST_HUNT;       // COUNT_TO_HUNT
                    cnt_nxt   = '0;
                end else if (eof_stb) begin
                    push    = 1'b1;            // COUNT_HOLD, closing flag
                    cnt_nxt = '0;
                end else if (flag_stb) begin
                    cnt_nxt = '0;              // COUNT_HOLD, idle flag
                end else begin
                    cnt_nxt = cnt_inc;         // COUNT_HOLD
                end
            end
            default: begin
                state_nxt = ST_HUNT;
                cnt_nxt   = '0;
            end
        endcase
    end

endmodule

// File: rtl/frmstat_store.sv
module frmstat_store #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 19,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level,
    output logic             overflow
);

    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop, do_push;

    assign empty   = (level == '0);
    assign full    = (level == LVL_FULL);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && (wr_ptr == PTR_W'(gi))) begin
                    mem[gi] <= push_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_adv(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_adv(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (push && !do_push) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/frmstat_fifo.sv
module frmstat_fifo
    import frmstat_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int STAT_W = DEF_STAT_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int ENT_W = CNT_W + STAT_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_stb,
    input  logic              flag_stb,
    input  logic              eof_stb,
    input  logic [STAT_W-1:0] frame_status,
    input  logic              rd_stb,
    output logic [ENT_W-1:0]  head_entry,
    output logic              empty,
    output logic              full,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);

    logic             push_w;
    logic [ENT_W-1:0] pdata_w;
    logic [CNT_W-1:0] cnt_w;
    logic             hunt_w;

    frmstat_track #(
        .CNT_W (CNT_W),
        .STAT_W(STAT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .byte_stb (byte_stb),
        .flag_stb (flag_stb),
        .eof_stb  (eof_stb),
        .status_in(frame_status),
        .push     (push_w),
        .push_data(pdata_w),
        .cnt      (cnt_w),
        .in_hunt  (hunt_w)
    );

    frmstat_store #(
        .DEPTH(DEPTH),
        .WIDTH(ENT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_w),
        .push_data(pdata_w),
        .pop      (rd_stb),
        .head     (head_entry),
        .empty    (empty),
        .full     (full),
        .level    (level),
        .overflow (overflow)
    );

endmodule

// File: rtl/frmstat_chk.sv
module frmstat_chk #(
    parameter int DEPTH = 10,
    parameter int CNT_W = 14,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             byte_stb,
    input logic             flag_stb,
    input logic             eof_stb,
    input logic             rd_stb,
    input logic             push,
    input logic             in_hunt,
    input logic [CNT_W-1:0] cnt,
    input logic             empty,
    input logic             full,
    input logic [LVL_W-1:0] level,
    input logic             overflow
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);

    // R6
    level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rd_stb && !full) |=> (level == $past(level) + 1'b1));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_stb && !push) |=> (empty && level == '0));

    // R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !rd_stb) |=> (overflow && level == LVL_FULL));

    // R8
    both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && rd_stb && !overflow) |=> (!overflow && level == LVL_FULL));

    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3
    hunt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hunt |-> !push);

    // R9
    off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> in_hunt);

    // R10
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hunt && enable && byte_stb && !flag_stb && !eof_stb && cnt == CNT_MAX)
        |=> (cnt == CNT_MAX));

endmodule

bind frmstat_fifo frmstat_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W),
    .LVL_W(LVL_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .byte_stb(byte_stb),
    .flag_stb(flag_stb),
    .eof_stb (eof_stb),
    .rd_stb  (rd_stb),
    .push    (push_w),
    .in_hunt (hunt_w),
    .cnt     (cnt_w),
    .empty   (empty),
    .full    (full),
    .level   (level),
    .overflow(overflow)
);

// File: tb/frmstat_fifo_test.sv
`timescale 1ns/1ps
module frmstat_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        byte_stb = 1'b0;
    logic        flag_stb = 1'b0;
    logic        eof_stb = 1'b0;
    logic [4:0]  frame_status = '0;
    logic        rd_stb = 1'b0;
    logic [18:0] head_entry;
    logic        empty, full, overflow;
    logic [3:0]  level;

    int checks = 0;
    int errors = 0;
    logic [18:0] expq[$];

    always #4 clk = ~clk;

    frmstat_fifo uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .byte_stb(byte_stb),
        .flag_stb(flag_stb), .eof_stb(eof_stb), .frame_status(frame_status),
        .rd_stb(rd_stb), .head_entry(head_entry), .empty(empty), .full(full),
        .level(level), .overflow(overflow)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares popped head with scoreboard front
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            if (expq.size() == 0) begin
                check(empty == 1'b1, "R7 read on empty", int'(empty), 1);
            end else begin
                check(head_entry == expq[0], "R6 head order", int'(head_entry), int'(expq[0]));
                void'(expq.pop_front());
            end
        end
    end

    task automatic pulse(input logic b, input logic f, input logic e,
                         input logic r, input logic [4:0] st);
        byte_stb = b; flag_stb = f; eof_stb = e; rd_stb = r; frame_status = st;
        @(posedge clk); #1;
        byte_stb = 0; flag_stb = 0; eof_stb = 0; rd_stb = 0; frame_status = '0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) pulse(1, 0, 0, 0, '0);
    endtask

    // driver: closes a frame and records the expected entry
    task automatic close(input int n, input logic [4:0] st, input logic rd, input logic b);
        logic [13:0] c;
        c = (n > 16383) ? 14'h3FFF : 14'(n);
        if (expq.size() < 10 || rd) expq.push_back({st, c});
        pulse(b, 0, 1, rd, st);
    endtask

    task automatic drain();
        while (expq.size() > 0) pulse(0, 0, 0, 1, '0);
        check(empty && level == 0, "R7 drained", int'(level), 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        expq.delete();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        do_reset();
        // R1
        check(empty && !full && level == 0 && !overflow, "R1 reset state", int'(level), 0);
        enable = 1;

        // R3: hunting, bytes and eof ignored
        bytes(3);
        pulse(0, 0, 1, 0, 5'h1F);
        check(level == 0, "R3 eof in hunt", int'(level), 0);
        pulse(0, 1, 0, 0, '0);
        check(level == 0, "R3 opening flag writes nothing", int'(level), 0);

        // R2 R4
        bytes(5);
        close(5, 5'h03, 0, 0);
        check(level == 1, "R4 one entry", int'(level), 1);
        bytes(7);
        close(8, 5'h10, 0, 1);              // R2 byte in closing cycle counts
        // R5 idle flag clears count
        bytes(4);
        pulse(0, 1, 0, 0, '0);
        bytes(2);
        close(2, 5'h0A, 0, 0);
        // R5 flag and eof together
        bytes(3);
        expq.push_back({5'h15, 14'd3});
        pulse(0, 1, 1, 0, 5'h15);
        check(level == 4, "R5 eof wins over flag", int'(level), 4);
        drain();
        pulse(0, 0, 0, 1, '0);              // R7 read on empty
        check(empty && level == 0, "R7 empty read no effect", int'(level), 0);

        // R6 fill to ten
        for (int k = 1; k <= 10; k++) begin
            bytes(k);
            close(k, 5'(k), 0, 0);
        end
        check(full && level == 10, "R6 full at ten", int'(level), 10);
        // R8 write with read while full
        bytes(11);
        close(11, 5'h1E, 1, 0);
        check(level == 10 && !overflow, "R8 write+read on full", int'(overflow), 0);
        // R8 write without read dropped
        bytes(12);
        close(12, 5'h01, 0, 0);
        check(level == 10 && overflow, "R8 drop sets overflow", int'(overflow), 1);
        drain();
        check(overflow == 1, "R8 overflow sticky", int'(overflow), 1);

        // R9 disabled: nothing written
        enable = 0;
        pulse(0, 1, 0, 0, '0);
        bytes(3);
        pulse(0, 0, 1, 0, 5'h02);
        check(level == 0, "R9 disabled no write", int'(level), 0);
        enable = 1;
        bytes(2);
        pulse(0, 0, 1, 0, 5'h02);
        check(level == 0, "R9 needs new flag", int'(level), 0);
        pulse(0, 1, 0, 0, '0);
        bytes(2);
        close(2, 5'h07, 0, 0);
        check(level == 1, "R9 logs after flag", int'(level), 1);
        enable = 0;
        pulse(0, 0, 0, 1, '0);
        check(level == 0, "R9 read while disabled", int'(level), 0);
        enable = 1;

        // R10 saturation
        pulse(0, 1, 0, 0, '0);
        bytes(16390);
        close(16390, 5'h0C, 0, 0);
        drain();

        // R8 reset clears overflow
        do_reset();
        check(!overflow && empty, "R8 overflow cleared by reset", int'(overflow), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule